// File: doc/BRIEF.md
# Per-Channel Circular Buffer Router

This block sits between a streaming serial-bus port and a shared byte-wide buffer RAM and serves up to 64 logical channels. Each channel owns a region of the RAM, described by a base address, a byte depth and a channel type. For isochronous channels the descriptor also gives a block size. Two allocation entries sit beside the descriptor, one for the inbound (writer) side and one for the outbound (reader) side, and each carries a type, a mute bit and an enable bit. The block keeps a write offset, a read offset and fill counts for every channel. It wraps both offsets inside the channel's region. It releases isochronous data to the reader only in whole blocks. It returns zero bytes while a channel is muted, disabled or empty.

Descriptors and allocation entries are loaded over a plain single-cycle write port. Inbound bytes arrive on a valid/ready stream tagged with a channel number. Reads are requested on a second valid/ready stream, and each accepted request produces one byte on a response stream one cycle later. Back-pressure works as follows. `in_ready` and `rd_ready` drop during any configuration write. `rd_ready` also drops while a response is held because `out_ready` is low, and the held response keeps its byte and channel until it is taken. Inbound bytes are never stalled for lack of space: they are dropped and flagged instead.

Top module: `chan_buf_router`

## Requirements
- R1: A descriptor write (`cfg_kind`=0, channel on `cfg_chan`, word layout: base [13:0], depth minus one [26:14], type [29:27], block size minus one [35:30]) clears that channel's offsets, counts and both flags. If the type is synchronous (0), it also sets the mute bit of both allocation entries.
- R2: An allocation write (`cfg_kind`=1, word layout: direction [0], type [3:1], channel label [9:4], mute [10], enable [11]) updates the inbound entry when direction is 0 and the outbound entry when direction is 1. An accepted inbound byte on an enabled entry is stored at base plus write offset, and the write offset wraps from depth minus one back to zero.
- R3: An inbound byte sent to a full channel (count equals depth) on an enabled entry is dropped and sets that channel's bit in `ovf_flags`. The bit stays set until the next descriptor write to that channel.
- R4: A read of an enabled, unmuted channel holding readable data returns the bytes in write order on `out_data`, with `out_valid` high in the cycle after the request is accepted.
- R5: A read of a channel with no readable byte returns zero, sets that channel's bit in `udf_flags` (sticky until the next descriptor write) and leaves the read offset unchanged.
- R6: While the mute bit of either allocation entry is set, reads return zero but still consume one byte and advance the read offset.
- R7: An entry counts as enabled only when its enable bit is set and its type equals the descriptor's type. A disabled inbound entry drops bytes without raising a flag. A disabled outbound entry returns zero but still consumes one byte.
- R8: On an isochronous channel (type 3), written bytes become readable only once a whole block of block-size bytes has been written.
- R9: `in_ready` and `rd_ready` are low during a configuration write. While `out_valid` is high and `out_ready` is low, `rd_ready` is low and `out_data` and `out_chan` hold.
- R10: After reset, `out_valid`, both flag vectors and all entries are zero, and `in_ready` and `rd_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 selects descriptor, 1 selects allocation entry |
| cfg_chan | input | 6 | Channel for a descriptor write |
| cfg_wdata | input | 36 | Configuration word |
| in_valid | input | 1 | Inbound byte valid |
| in_ready | output | 1 | Inbound byte accepted |
| in_chan | input | 6 | Inbound channel label |
| in_data | input | 8 | Inbound byte |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_chan | input | 6 | Channel to read |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Response taken |
| out_chan | output | 6 | Channel of the response |
| out_data | output | 8 | Response byte |
| ovf_flags | output | 64 | Sticky overflow flag per channel |
| udf_flags | output | 64 | Sticky underflow flag per channel |

## Verification
The hardest state to reach is a read that consumes a byte yet returns zero: a muted or type-mismatched outbound entry over a non-empty buffer. From the ports it looks the same as an underflow. The bench tells the two apart by re-enabling the entry afterwards and reading again. If the byte was consumed, the follow-up read returns zero. A later write then comes back intact, which shows the offsets stayed aligned. Isochronous partial blocks and offset wrap after an overflow are reached by sequences that fill a region past its depth.

// File: rtl/chan_router_pkg.sv
package chan_router_pkg;
  localparam int LBL_W   = 6;
  localparam int BASE_W  = 14;
  localparam int DEPTH_W = 13;
  localparam int TYPE_W  = 3;
  localparam int BLK_W   = 6;
  localparam int DATA_W  = 8;

  typedef enum logic [TYPE_W-1:0] {
    CT_SYNC  = 3'd0,
    CT_CTRL  = 3'd1,
    CT_ASYNC = 3'd2,
    CT_ISO   = 3'd3
  } chan_type_e;

  typedef struct packed {
    logic [BLK_W-1:0]   blk_m1;
    logic [TYPE_W-1:0]  ctype;
    logic [DEPTH_W-1:0] depth_m1;
    logic [BASE_W-1:0]  base;
  } desc_t;

  typedef struct packed {
    logic               en;
    logic               mute;
    logic [LBL_W-1:0]   label;
    logic [TYPE_W-1:0]  ctype;
    logic               dir;
  } alloc_t;

  typedef struct packed {
    logic               en;
    logic               mute;
    logic [TYPE_W-1:0]  ctype;
  } entry_t;

  localparam int CFG_W   = $bits(desc_t);
  localparam int ALLOC_W = $bits(alloc_t);
endpackage

// File: rtl/chan_cfg_store.sv
module chan_cfg_store
  import chan_router_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [LBL_W-1:0]  cfg_chan,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output desc_t             desc_q [NUM_CH],
  output logic [NUM_CH-1:0] desc_wr,
  output logic [NUM_CH-1:0] in_en,
  output logic [NUM_CH-1:0] out_en,
  output logic [NUM_CH-1:0] muted,
  output logic [NUM_CH-1:0] iso
);
  alloc_t new_alloc;
  desc_t  new_desc;

  assign new_alloc = alloc_t'(cfg_wdata[ALLOC_W-1:0]);
  assign new_desc  = desc_t'(cfg_wdata);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    entry_t ent_in, ent_out;
    logic   desc_hit, alloc_hit;

    assign desc_hit  = cfg_we && !cfg_kind && (cfg_chan == LBL_W'(i));
    assign alloc_hit = cfg_we &&  cfg_kind && (new_alloc.label == LBL_W'(i));
    assign desc_wr[i] = desc_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        desc_q[i] <= '0;
        ent_in    <= '0;
        ent_out   <= '0;
      end else if (desc_hit) begin
        desc_q[i] <= new_desc;
        if (new_desc.ctype == CT_SYNC) begin
          ent_in.mute  <= 1'b1;
          ent_out.mute <= 1'b1;
        end
      end else if (alloc_hit) begin
        if (new_alloc.dir) begin
          ent_out <= '{en: new_alloc.en, mute: new_alloc.mute, ctype: new_alloc.ctype};
        end else begin
          ent_in  <= '{en: new_alloc.en, mute: new_alloc.mute, ctype: new_alloc.ctype};
        end
      end
    end

    assign in_en[i]  = ent_in.en  && (ent_in.ctype  == desc_q[i].ctype);
    assign out_en[i] = ent_out.en && (ent_out.ctype == desc_q[i].ctype);
    assign muted[i]  = ent_in.mute || ent_out.mute;
    assign iso[i]    = (desc_q[i].ctype == CT_ISO);
  end
endmodule

// File: rtl/chan_ptr_state.sv
module chan_ptr_state
  import chan_router_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  desc_t             desc_q [NUM_CH],
  input  logic [NUM_CH-1:0] desc_wr,
  input  logic [NUM_CH-1:0] iso,
  input  logic              wr_go,
  input  logic [LBL_W-1:0]  wr_chan,
  input  logic              rd_go,
  input  logic [LBL_W-1:0]  rd_chan,
  output logic [NUM_CH-1:0] full,
  output logic [NUM_CH-1:0] avail,
  output logic [RAM_AW-1:0] wr_addr,
  output logic [RAM_AW-1:0] rd_addr
);
  localparam int CNT_W = DEPTH_W + 1;

  logic [DEPTH_W-1:0] wp [NUM_CH];
  logic [DEPTH_W-1:0] rp [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CNT_W-1:0] cnt, rel, add;
    logic [BLK_W-1:0] bfill;
    logic             wr_i, rd_i, blk_done;
    logic [DEPTH_W-1:0] lim;

    assign lim      = desc_q[i].depth_m1;
    assign wr_i     = wr_go && (wr_chan == LBL_W'(i));
    assign rd_i     = rd_go && (rd_chan == LBL_W'(i));
    assign blk_done = wr_i && (!iso[i] || (bfill == desc_q[i].blk_m1));
    assign add      = iso[i] ? CNT_W'(desc_q[i].blk_m1) + CNT_W'(1) : CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp[i] <= '0; rp[i] <= '0; cnt <= '0; rel <= '0; bfill <= '0;
      end else if (desc_wr[i]) begin
        wp[i] <= '0; rp[i] <= '0; cnt <= '0; rel <= '0; bfill <= '0;
      end else begin
        if (wr_i) wp[i] <= (wp[i] == lim) ? '0 : wp[i] + 1'b1;
        if (rd_i) rp[i] <= (rp[i] == lim) ? '0 : rp[i] + 1'b1;
        cnt <= cnt + CNT_W'(wr_i) - CNT_W'(rd_i);
        rel <= rel + (blk_done ? add : '0) - CNT_W'(rd_i);
        if (wr_i && iso[i])
          bfill <= (bfill == desc_q[i].blk_m1) ? '0 : bfill + 1'b1;
      end
    end

    assign full[i]  = (cnt == ({1'b0, lim} + CNT_W'(1)));
    assign avail[i] = (rel != '0);
  end

  assign wr_addr = RAM_AW'(desc_q[wr_chan].base + BASE_W'(wp[wr_chan]));
  assign rd_addr = RAM_AW'(desc_q[rd_chan].base + BASE_W'(rp[rd_chan]));
endmodule

// File: rtl/chan_buf_ram.sv
module chan_buf_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/chan_buf_router.sv
module chan_buf_router
  import chan_router_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [LBL_W-1:0]  cfg_chan,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LBL_W-1:0]  in_chan,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [LBL_W-1:0]  rd_chan,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LBL_W-1:0]  out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic [NUM_CH-1:0] ovf_flags,
  output logic [NUM_CH-1:0] udf_flags
);
  desc_t             desc_q [NUM_CH];
  logic [NUM_CH-1:0] desc_wr, in_en, out_en, muted, iso, full, avail;
  logic [RAM_AW-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] ram_q;
  logic              in_fire, rd_fire, wr_go, rd_go, zero_q, out_valid_q;
  logic [LBL_W-1:0]  out_chan_q;
  logic [NUM_CH-1:0] in_sel, rd_sel, ovf_set, udf_set;

  chan_cfg_store #(.NUM_CH(NUM_CH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata), .desc_q(desc_q),
    .desc_wr(desc_wr), .in_en(in_en), .out_en(out_en), .muted(muted), .iso(iso)
  );

  chan_ptr_state #(.NUM_CH(NUM_CH), .RAM_AW(RAM_AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .desc_q(desc_q), .desc_wr(desc_wr), .iso(iso),
    .wr_go(wr_go), .wr_chan(in_chan), .rd_go(rd_go), .rd_chan(rd_chan),
    .full(full), .avail(avail), .wr_addr(wr_addr), .rd_addr(rd_addr)
  );

  chan_buf_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .we(wr_go), .waddr(wr_addr), .wdata(in_data),
    .re(rd_fire), .raddr(rd_addr), .rdata(ram_q)
  );

  // Stream handshakes: configuration owns the cycle, responses may stall reads.
  assign in_ready = !cfg_we;
  assign rd_ready = !cfg_we && (!out_valid_q || out_ready);
  assign in_fire  = in_valid && in_ready;
  assign rd_fire  = rd_valid && rd_ready;

  assign in_sel = NUM_CH'(1) << in_chan;
  assign rd_sel = NUM_CH'(1) << rd_chan;

  assign wr_go   = in_fire && in_en[in_chan] && !full[in_chan];
  assign rd_go   = rd_fire && avail[rd_chan];
  assign ovf_set = (in_fire && in_en[in_chan] && full[in_chan]) ? in_sel : '0;
  assign udf_set = (rd_fire && !avail[rd_chan]) ? rd_sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flags <= '0;
      udf_flags <= '0;
    end else begin
      ovf_flags <= (ovf_flags & ~desc_wr) | ovf_set;
      udf_flags <= (udf_flags & ~desc_wr) | udf_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_chan_q  <= '0;
      zero_q      <= 1'b1;
    end else if (rd_fire) begin
      out_valid_q <= 1'b1;
      out_chan_q  <= rd_chan;
      zero_q      <= !avail[rd_chan] || !out_en[rd_chan] || muted[rd_chan];
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_chan  = out_chan_q;
  assign out_data  = zero_q ? '0 : ram_q;
endmodule

// File: rtl/chan_buf_router_chk.sv
module chan_buf_router_chk #(
  parameter int NUM_CH = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_kind,
  input logic              in_ready,
  input logic              rd_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [5:0]        out_chan,
  input logic [7:0]        out_data,
  input logic [NUM_CH-1:0] ovf_flags,
  input logic [NUM_CH-1:0] udf_flags
);
  logic desc_wr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) desc_wr_q <= 1'b0;
    else        desc_wr_q <= cfg_we && !cfg_kind;
  end

  // R9: configuration takes priority over both input streams
  p_cfg_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (!in_ready && !rd_ready));

  // R9: held response keeps its contents
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  // R9: no new request while a response is stalled
  p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !rd_ready);

  // R3: overflow flags clear only through a descriptor write
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !cfg_kind) |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

  // R5: underflow flags clear only through a descriptor write
  p_udf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !cfg_kind) |=> ((udf_flags & $past(udf_flags)) == $past(udf_flags)));

  // R5: a newly raised underflow comes with a zero response
  p_udf_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_wr_q && ((udf_flags & ~$past(udf_flags)) != '0)) |-> (out_valid && out_data == 8'h00));

  // R5: at most one channel raises an underflow per cycle
  p_udf_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(udf_flags & ~$past(udf_flags)));
endmodule

bind chan_buf_router chan_buf_router_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
  .in_ready(in_ready), .rd_ready(rd_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data),
  .ovf_flags(ovf_flags), .udf_flags(udf_flags)
);

// File: tb/chan_buf_router_bench.sv
`timescale 1ns/1ps
module chan_buf_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_kind = 1'b0;
  logic [5:0]  cfg_chan = '0;
  logic [35:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_chan = '0;
  logic [7:0]  in_data = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [5:0]  rd_chan = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [5:0]  out_chan;
  logic [7:0]  out_data;
  logic [63:0] ovf_flags, udf_flags;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chan_buf_router u_chan_buf_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_chan(rd_chan),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_data(out_data), .ovf_flags(ovf_flags), .udf_flags(udf_flags)
  );

  // op[23:22] 0=write 1=read-and-compare, ch[21:16], data[15:8], expected[7:0]
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 6'd1, 8'h11, 8'h00}, {2'd0, 6'd1, 8'h22, 8'h00},
    {2'd1, 6'd1, 8'h00, 8'h11}, {2'd0, 6'd1, 8'h33, 8'h00},
    {2'd1, 6'd1, 8'h00, 8'h22}, {2'd1, 6'd1, 8'h00, 8'h33},
    {2'd0, 6'd3, 8'hA0, 8'h00}, {2'd0, 6'd3, 8'hA1, 8'h00},
    {2'd0, 6'd3, 8'hA2, 8'h00}, {2'd1, 6'd3, 8'h00, 8'h00},
    {2'd0, 6'd3, 8'hA3, 8'h00}, {2'd1, 6'd3, 8'h00, 8'hA0},
    {2'd1, 6'd3, 8'h00, 8'hA1}, {2'd1, 6'd3, 8'h00, 8'hA2},
    {2'd1, 6'd3, 8'h00, 8'hA3}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cfg(input bit kind, input logic [5:0] ch, input logic [35:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_chan = ch; cfg_wdata = w;
    #1;
    chk(!in_ready && !rd_ready, "R9 stall during cfg", {in_ready, rd_ready}, 0);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic desc(input logic [5:0] ch, input int base, input int bytes, input int ty, input int blk);
    cfg(1'b0, ch, {6'(blk - 1), 3'(ty), 13'(bytes - 1), 14'(base)});
  endtask

  task automatic alloc(input logic [5:0] ch, input bit dir, input int ty, input bit mute, input bit en);
    cfg(1'b1, 6'd0, {24'd0, en, mute, ch, 3'(ty), dir});
  endtask

  task automatic wr(input logic [5:0] ch, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_chan = ch; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] ch, output logic [7:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_chan = ch;
    @(negedge clk);
    rd_valid = 1'b0;
    d = out_valid ? out_data : 8'hxx;
  endtask

  task automatic rd_exp(input logic [5:0] ch, input logic [7:0] e, input string req);
    logic [7:0] d;
    rd(ch, d);
    chk(d === e && out_chan == ch, req, {out_chan, d}, {ch, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!out_valid && ovf_flags == 0 && udf_flags == 0 && in_ready && rd_ready,
        "R10 reset state", {out_valid, in_ready, rd_ready}, 3'b011);
    rst_n = 1'b1;

    // R1/R2 setup: ch1 async depth 8, ch3 iso depth 8 block 4
    desc(6'd1, 'h040, 8, 2, 1);
    alloc(6'd1, 1'b0, 2, 1'b0, 1'b1);
    alloc(6'd1, 1'b1, 2, 1'b0, 1'b1);
    desc(6'd3, 'h080, 8, 3, 4);
    alloc(6'd3, 1'b0, 3, 1'b0, 1'b1);
    alloc(6'd3, 1'b1, 3, 1'b0, 1'b1);

    // R4 / R8 vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23:22] == 2'd0) wr(VEC[i][21:16], VEC[i][15:8]);
      else rd_exp(VEC[i][21:16], VEC[i][7:0], "R4/R8 vector read");
    end
    chk(udf_flags[3] && !udf_flags[1], "R8 partial block unreadable", udf_flags[3:0], 4'b1000);

    // R3 overflow, R2 wrap
    for (int i = 0; i < 9; i++) wr(6'd1, 8'(8'h80 + i));
    chk(ovf_flags[1] == 1'b1, "R3 overflow flag", ovf_flags[1], 1);
    for (int i = 0; i < 8; i++) rd_exp(6'd1, 8'(8'h80 + i), "R2 wrap order");
    rd_exp(6'd1, 8'h00, "R5 empty read zero");
    chk(udf_flags[1] && ovf_flags[1], "R5 underflow flag, R3 sticky", {udf_flags[1], ovf_flags[1]}, 2'b11);
    wr(6'd1, 8'h99);
    rd_exp(6'd1, 8'h99, "R5 no pointer move on underflow");

    // R7 disabled inbound entry drops silently
    alloc(6'd1, 1'b0, 2, 1'b0, 1'b0);
    wr(6'd1, 8'h77);
    alloc(6'd1, 1'b0, 2, 1'b0, 1'b1);
    rd_exp(6'd1, 8'h00, "R7 disabled inbound dropped");
    // R7 type mismatch on outbound: zero but consumes
    alloc(6'd1, 1'b1, 0, 1'b0, 1'b1);
    wr(6'd1, 8'h44);
    rd_exp(6'd1, 8'h00, "R7 mismatched outbound zero");
    alloc(6'd1, 1'b1, 2, 1'b0, 1'b1);
    rd_exp(6'd1, 8'h00, "R7 byte was consumed");
    wr(6'd1, 8'h45);
    rd_exp(6'd1, 8'h45, "R7 alignment kept");

    // R1 descriptor write clears flags; R1/R6 synchronous channel starts muted
    desc(6'd1, 'h040, 8, 2, 1);
    chk(!ovf_flags[1] && !udf_flags[1], "R1 flags cleared", {ovf_flags[1], udf_flags[1]}, 0);
    alloc(6'd2, 1'b0, 0, 1'b0, 1'b1);
    alloc(6'd2, 1'b1, 0, 1'b0, 1'b1);
    desc(6'd2, 'h0C0, 4, 0, 1);
    wr(6'd2, 8'h55);
    rd_exp(6'd2, 8'h00, "R1 sync muted after configure");
    alloc(6'd2, 1'b1, 0, 1'b0, 1'b1);
    wr(6'd2, 8'h56);
    rd_exp(6'd2, 8'h00, "R6 inbound mute still zeroes");
    alloc(6'd2, 1'b0, 0, 1'b0, 1'b1);
    wr(6'd2, 8'h57);
    rd_exp(6'd2, 8'h57, "R6 muted reads advanced pointer");
    chk(!udf_flags[2], "R6 muted reads not underflow", udf_flags[2], 0);

    // R9 back-pressure on the response stream
    wr(6'd1, 8'h61);
    wr(6'd1, 8'h62);
    out_ready = 1'b0;
    rd(6'd1, d);
    chk(d == 8'h61 && !rd_ready, "R9 stalled response", {rd_ready, d}, 9'h061);
    repeat (2) @(negedge clk);
    chk(out_valid && out_data == 8'h61 && out_chan == 6'd1, "R9 response held", out_data, 8'h61);
    out_ready = 1'b1;
    @(negedge clk);
    chk(!out_valid && rd_ready, "R9 response released", {out_valid, rd_ready}, 2'b01);
    rd_exp(6'd1, 8'h62, "R9 next byte after stall");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule